// File: doc/BRIEF.md
# Serialized Lane-Group Integer Issue Unit

This block takes two-operand integer instructions for a single 32-lane warp and pushes each one through a set of pipelined lane units. When the unit count `UNITS` is smaller than the lane count, an instruction is spread over `LANES/UNITS` consecutive issue cycles. Each cycle covers one group of adjacent lanes, taken in ascending order. Every group comes back on the write-back port exactly `LAT` cycles after it was issued, so the groups of one instruction return on consecutive cycles.

Each lane has its own small register file. A scoreboard keeps one pending bit per register. An instruction whose sources or destination still have results in flight is held at the input handshake until the last group of that earlier result has been written. The active-lane mask only gates the register writes. Masked-off lanes still take their issue slots and travel through the pipeline as bubbles, so a nearly empty warp costs as many cycles as a full one.

Top module: `simd_issue_unit`

## Requirements
- R1: Every accepted instruction produces exactly `LANES/UNITS` write-back beats, whatever the lane mask, and this includes an all-zero mask.
- R2: Beat k carries group index k on `wb_grp_o` and covers lanes k*UNITS to k*UNITS+UNITS-1. Lane k*UNITS+u sits in slice u of `wb_data_o`. Beats come in ascending group order with no gaps.
- R3: If an instruction is accepted in cycle t, its group k is on the write-back port in cycle t+k+LAT.
- R4: `in_ready_o` is low while the remaining groups of an accepted instruction are issuing. An instruction with no pending register is accepted in cycle t+LANES/UNITS.
- R5: An add whose source register is pending is not accepted until the cycle after the last write-back of that register, which is cycle t+LANES/UNITS+LAT at the earliest. While it waits with `in_valid_i` high, `stall_o` is high.
- R6: An instruction whose destination register is pending is held back in the same way as R5.
- R7: Bit u of `wb_mask_o` equals bit k*UNITS+u of the accepted mask. A lane whose mask bit is 0 keeps its old register value.
- R8: Opcode 0 writes rs1+rs2 modulo 2^32 in each lane. Opcode 1 writes imm+lane index in each lane, and it reads no source.
- R9: After reset, all registers read zero, `in_ready_o` is 1, and `busy_o` and `wb_valid_o` are 0.
- R10: For an instruction accepted in cycle t with nothing else in flight, `busy_o` is high in cycles t+1 through t+LANES/UNITS-1+LAT and low otherwise.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| in_valid_i | input | 1 | Instruction offered |
| in_ready_o | output | 1 | Instruction accepted when high together with valid |
| in_op_i | input | 1 | 0 = add registers, 1 = load immediate plus lane index |
| in_rd_i | input | $clog2(NREG) | Destination register |
| in_rs1_i | input | $clog2(NREG) | First source register |
| in_rs2_i | input | $clog2(NREG) | Second source register |
| in_imm_i | input | DW | Immediate for opcode 1 |
| in_mask_i | input | LANES | Active-lane mask |
| wb_valid_o | output | 1 | Write-back beat present |
| wb_grp_o | output | max($clog2(LANES/UNITS),1) | Lane group of the beat |
| wb_rd_o | output | $clog2(NREG) | Register being written |
| wb_mask_o | output | UNITS | Active lanes in the beat |
| wb_data_o | output | UNITS*DW | Lane results, lowest lane in the low slice |
| busy_o | output | 1 | Groups still issuing or in the pipeline |
| stall_o | output | 1 | Offered instruction blocked by a pending register |

## Verification
The bench runs with four units, which gives eight groups per instruction. It checks the spacing between acceptances for three cases: back-to-back independent instructions, a read-after-write pair, and a write-after-write pair. These separate pure serialization cost from a scoreboard stall. Full, two-lane and empty masks are each followed by a full read of the register. A correct beat count and spacing there, with untouched inactive lanes, shows that masking gates the writes only and not the issue. Loads near 2^32 followed by adds check per-lane wraparound and lane ordering within each group slice.

// File: rtl/su_pkg.sv
package su_pkg;
  typedef enum logic {
    OP_ADD = 1'b0,
    OP_LDI = 1'b1
  } op_e;
endpackage

// File: rtl/su_regfile.sv
module su_regfile #(
  parameter int LANES = 32,
  parameter int UNITS = 16,
  parameter int DW    = 32,
  parameter int NREG  = 8,
  localparam int G    = LANES / UNITS,
  localparam int GW   = (G > 1) ? $clog2(G) : 1,
  localparam int RW   = $clog2(NREG),
  localparam int LW   = $clog2(LANES)
) (
  input  logic                clk_i,
  input  logic                rst_ni,
  input  logic [GW-1:0]       rd_grp_i,
  input  logic [RW-1:0]       rs1_i,
  input  logic [RW-1:0]       rs2_i,
  output logic [UNITS*DW-1:0] rs1_data_o,
  output logic [UNITS*DW-1:0] rs2_data_o,
  input  logic                we_i,
  input  logic [GW-1:0]       wr_grp_i,
  input  logic [RW-1:0]       wr_rd_i,
  input  logic [UNITS-1:0]    wr_mask_i,
  input  logic [UNITS*DW-1:0] wr_data_i
);
  logic [DW-1:0] mem_q [NREG][LANES];

  for (genvar u = 0; u < UNITS; u++) begin : g_rd
    logic [LW-1:0] lane;
    assign lane = LW'(int'(rd_grp_i) * UNITS + u);
    assign rs1_data_o[u*DW +: DW] = mem_q[rs1_i][lane];
    assign rs2_data_o[u*DW +: DW] = mem_q[rs2_i][lane];
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      for (int r = 0; r < NREG; r++)
        for (int l = 0; l < LANES; l++)
          mem_q[r][l] <= '0;
    end else if (we_i) begin
      for (int u = 0; u < UNITS; u++)
        if (wr_mask_i[u])
          mem_q[wr_rd_i][LW'(int'(wr_grp_i) * UNITS + u)] <= wr_data_i[u*DW +: DW];
    end
  end
endmodule

// File: rtl/su_lane_alu.sv
module su_lane_alu #(
  parameter int DW = 32,
  parameter int LW = 5
) (
  input  su_pkg::op_e    op_i,
  input  logic [DW-1:0]  a_i,
  input  logic [DW-1:0]  b_i,
  input  logic [DW-1:0]  imm_i,
  input  logic [LW-1:0]  lane_i,
  output logic [DW-1:0]  res_o
);
  assign res_o = (op_i == su_pkg::OP_LDI) ? imm_i + DW'(lane_i) : a_i + b_i;
endmodule

// File: rtl/su_fu_pipe.sv
module su_fu_pipe #(
  parameter int W   = 8,
  parameter int LAT = 4
) (
  input  logic         clk_i,
  input  logic         rst_ni,
  input  logic [W-1:0] in_i,
  output logic [W-1:0] out_o,
  output logic         any_vld_o
);
  logic [W-1:0] stg_q [LAT];

  for (genvar s = 0; s < LAT; s++) begin : g_stg
    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni)     stg_q[s] <= '0;
      else if (s == 0) stg_q[s] <= in_i;
      else             stg_q[s] <= stg_q[(s > 0) ? s-1 : 0];
    end
  end

  assign out_o = stg_q[LAT-1];

  // bit 0 of each stage is its valid flag
  always_comb begin
    any_vld_o = 1'b0;
    for (int s = 0; s < LAT; s++) any_vld_o = any_vld_o | stg_q[s][0];
  end
endmodule

// File: rtl/su_scoreboard.sv
module su_scoreboard #(
  parameter int NREG = 8,
  localparam int RW  = $clog2(NREG)
) (
  input  logic            clk_i,
  input  logic            rst_ni,
  input  logic            set_i,
  input  logic [RW-1:0]   set_rd_i,
  input  logic            clr_i,
  input  logic [RW-1:0]   clr_rd_i,
  output logic [NREG-1:0] pend_o
);
  logic [NREG-1:0] pend_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) pend_q <= '0;
    else begin
      for (int r = 0; r < NREG; r++) begin
        if (set_i && set_rd_i == RW'(r))      pend_q[r] <= 1'b1;
        else if (clr_i && clr_rd_i == RW'(r)) pend_q[r] <= 1'b0;
      end
    end
  end

  assign pend_o = pend_q;

  for (genvar r = 0; r < NREG; r++) begin : g_chk
    assert_clr_on_last_wb_R5: assert property (@(posedge clk_i) disable iff (!rst_ni)
      $fell(pend_q[r]) |-> $past(clr_i && clr_rd_i == RW'(r)));
    assert_set_on_accept_R6: assert property (@(posedge clk_i) disable iff (!rst_ni)
      $rose(pend_q[r]) |-> $past(set_i && set_rd_i == RW'(r)));
    assert_no_double_set_R6: assert property (@(posedge clk_i) disable iff (!rst_ni)
      (set_i && set_rd_i == RW'(r)) |-> !pend_q[r]);
  end
endmodule

// File: rtl/simd_issue_unit.sv
module simd_issue_unit #(
  parameter int LANES = 32,
  parameter int UNITS = 16,
  parameter int LAT   = 4,
  parameter int DW    = 32,
  parameter int NREG  = 8,
  localparam int G    = LANES / UNITS,
  localparam int GW   = (G > 1) ? $clog2(G) : 1,
  localparam int RW   = $clog2(NREG),
  localparam int LW   = $clog2(LANES)
) (
  input  logic                clk_i,
  input  logic                rst_ni,
  input  logic                in_valid_i,
  output logic                in_ready_o,
  input  logic                in_op_i,
  input  logic [RW-1:0]       in_rd_i,
  input  logic [RW-1:0]       in_rs1_i,
  input  logic [RW-1:0]       in_rs2_i,
  input  logic [DW-1:0]       in_imm_i,
  input  logic [LANES-1:0]    in_mask_i,
  output logic                wb_valid_o,
  output logic [GW-1:0]       wb_grp_o,
  output logic [RW-1:0]       wb_rd_o,
  output logic [UNITS-1:0]    wb_mask_o,
  output logic [UNITS*DW-1:0] wb_data_o,
  output logic                busy_o,
  output logic                stall_o
);
  import su_pkg::*;

  localparam int PW = 2 + RW + GW + UNITS + UNITS*DW;

  // held instruction for groups 1..G-1
  op_e              op_q;
  logic [RW-1:0]    rd_q, rs1_q, rs2_q;
  logic [DW-1:0]    imm_q;
  logic [LANES-1:0] mask_q;
  logic [GW-1:0]    cnt_q;

  logic             iss_rem, accept, fire, raw_haz, cur_last;
  op_e              cur_op;
  logic [RW-1:0]    cur_rd, cur_rs1, cur_rs2;
  logic [DW-1:0]    cur_imm;
  logic [LANES-1:0] cur_mask;
  logic [GW-1:0]    cur_grp;
  logic [NREG-1:0]  pend;

  logic [UNITS*DW-1:0] opa, opb, res;
  logic [PW-1:0]       p_in, p_out;
  logic                pipe_busy;

  logic                p_vld, p_last;
  logic [RW-1:0]       p_rd;
  logic [GW-1:0]       p_grp;
  logic [UNITS-1:0]    p_mask;
  logic [UNITS*DW-1:0] p_data;

  assign iss_rem = (cnt_q != '0);
  assign raw_haz = (op_e'(in_op_i) == OP_ADD && (pend[in_rs1_i] || pend[in_rs2_i]))
                   || pend[in_rd_i];
  assign in_ready_o = !iss_rem && !raw_haz;
  assign stall_o    = in_valid_i && raw_haz;
  assign accept     = in_valid_i && in_ready_o;
  assign fire       = accept || iss_rem;

  assign cur_op   = iss_rem ? op_q   : op_e'(in_op_i);
  assign cur_rd   = iss_rem ? rd_q   : in_rd_i;
  assign cur_rs1  = iss_rem ? rs1_q  : in_rs1_i;
  assign cur_rs2  = iss_rem ? rs2_q  : in_rs2_i;
  assign cur_imm  = iss_rem ? imm_q  : in_imm_i;
  assign cur_mask = iss_rem ? mask_q : in_mask_i;
  assign cur_grp  = iss_rem ? cnt_q  : '0;
  assign cur_last = (cur_grp == GW'(G-1));

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      cnt_q  <= '0;
      op_q   <= OP_ADD;
      rd_q   <= '0;
      rs1_q  <= '0;
      rs2_q  <= '0;
      imm_q  <= '0;
      mask_q <= '0;
    end else if (accept) begin
      cnt_q  <= (G > 1) ? GW'(1) : '0;
      op_q   <= op_e'(in_op_i);
      rd_q   <= in_rd_i;
      rs1_q  <= in_rs1_i;
      rs2_q  <= in_rs2_i;
      imm_q  <= in_imm_i;
      mask_q <= in_mask_i;
    end else if (iss_rem) begin
      cnt_q  <= (cnt_q == GW'(G-1)) ? '0 : cnt_q + GW'(1);
    end
  end

  su_regfile #(.LANES(LANES), .UNITS(UNITS), .DW(DW), .NREG(NREG)) u_rf (
    .clk_i      (clk_i),
    .rst_ni     (rst_ni),
    .rd_grp_i   (cur_grp),
    .rs1_i      (cur_rs1),
    .rs2_i      (cur_rs2),
    .rs1_data_o (opa),
    .rs2_data_o (opb),
    .we_i       (p_vld),
    .wr_grp_i   (p_grp),
    .wr_rd_i    (p_rd),
    .wr_mask_i  (p_mask),
    .wr_data_i  (p_data)
  );

  for (genvar u = 0; u < UNITS; u++) begin : g_fu
    logic [LW-1:0] lane;
    assign lane = LW'(int'(cur_grp) * UNITS + u);
    su_lane_alu #(.DW(DW), .LW(LW)) u_alu (
      .op_i   (cur_op),
      .a_i    (opa[u*DW +: DW]),
      .b_i    (opb[u*DW +: DW]),
      .imm_i  (cur_imm),
      .lane_i (lane),
      .res_o  (res[u*DW +: DW])
    );
  end

  // inactive lanes travel as bubbles: slot kept, write gated by mask
  assign p_in = fire ? {res, cur_mask[int'(cur_grp)*UNITS +: UNITS], cur_grp, cur_rd, cur_last, 1'b1}
                     : '0;

  su_fu_pipe #(.W(PW), .LAT(LAT)) u_pipe (
    .clk_i     (clk_i),
    .rst_ni    (rst_ni),
    .in_i      (p_in),
    .out_o     (p_out),
    .any_vld_o (pipe_busy)
  );

  assign {p_data, p_mask, p_grp, p_rd, p_last, p_vld} = p_out;

  su_scoreboard #(.NREG(NREG)) u_sb (
    .clk_i    (clk_i),
    .rst_ni   (rst_ni),
    .set_i    (accept),
    .set_rd_i (in_rd_i),
    .clr_i    (p_vld && p_last),
    .clr_rd_i (p_rd),
    .pend_o   (pend)
  );

  assign wb_valid_o = p_vld;
  assign wb_grp_o   = p_grp;
  assign wb_rd_o    = p_rd;
  assign wb_mask_o  = p_mask;
  assign wb_data_o  = p_data;
  assign busy_o     = iss_rem || pipe_busy;

  assert_last_is_top_grp_R1: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (p_vld && p_last) |-> (p_grp == GW'(G-1)));

  assert_stall_blocks_R5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    stall_o |-> !in_ready_o);

  if (G > 1) begin : g_multi
    assert_grp_ascend_R2: assert property (@(posedge clk_i) disable iff (!rst_ni)
      (p_vld && !p_last) |=> (wb_valid_o && wb_grp_o == $past(wb_grp_o) + GW'(1)));
    assert_hold_ready_R4: assert property (@(posedge clk_i) disable iff (!rst_ni)
      (in_valid_i && in_ready_o) |=> !in_ready_o);
  end
endmodule

// File: tb/tb_simd_issue_unit.sv
module tb_simd_issue_unit;
  localparam int LANES = 32;
  localparam int U     = 4;
  localparam int LAT   = 4;
  localparam int DW    = 32;
  localparam int NREG  = 8;
  localparam int G     = LANES / U;
  localparam int GW    = $clog2(G);
  localparam int RW    = $clog2(NREG);

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  always #10 clk = ~clk;

  logic             in_valid = 1'b0, in_op = 1'b0;
  logic [RW-1:0]    in_rd = '0, in_rs1 = '0, in_rs2 = '0;
  logic [DW-1:0]    in_imm = '0;
  logic [LANES-1:0] in_mask = '0;
  logic             in_ready, wb_valid, busy, stall;
  logic [GW-1:0]    wb_grp;
  logic [RW-1:0]    wb_rd;
  logic [U-1:0]     wb_mask;
  logic [U*DW-1:0]  wb_data;

  simd_issue_unit #(.LANES(LANES), .UNITS(U), .LAT(LAT), .DW(DW), .NREG(NREG)) dut (
    .clk_i(clk), .rst_ni(rst_n), .in_valid_i(in_valid), .in_ready_o(in_ready),
    .in_op_i(in_op), .in_rd_i(in_rd), .in_rs1_i(in_rs1), .in_rs2_i(in_rs2),
    .in_imm_i(in_imm), .in_mask_i(in_mask), .wb_valid_o(wb_valid), .wb_grp_o(wb_grp),
    .wb_rd_o(wb_rd), .wb_mask_o(wb_mask), .wb_data_o(wb_data), .busy_o(busy),
    .stall_o(stall)
  );

  typedef struct {
    int              grp;
    int              rd;
    logic [U-1:0]    mask;
    logic [U*DW-1:0] data;
    int              cyc;
  } beat_t;

  beat_t         exp_q[$];
  logic [DW-1:0] mdl [NREG][LANES];
  int cyc = 0, n_chk = 0, n_err = 0;
  bit done = 1'b0;

  always @(posedge clk) cyc <= cyc + 1;

  task automatic chk(input bit ok, input string req, input logic [U*DW-1:0] act,
                     input logic [U*DW-1:0] exp);
    n_chk++;
    if (!ok) begin
      n_err++;
      $display("FAIL %s actual=%0h expected=%0h (cycle %0d)", req, act, exp, cyc);
    end
  endtask

  // driver: offers one instruction, returns the acceptance cycle and whether stall_o was seen
  task automatic send(input bit op, input int rd, input int rs1, input int rs2,
                      input logic [DW-1:0] imm, input logic [LANES-1:0] mask,
                      output int acc, output bit stalled);
    logic [DW-1:0] r [LANES];
    beat_t b;
    stalled = 1'b0;
    in_valid = 1'b1; in_op = op; in_rd = RW'(rd); in_rs1 = RW'(rs1); in_rs2 = RW'(rs2);
    in_imm = imm; in_mask = mask;
    #1;
    while (!in_ready) begin
      if (stall) stalled = 1'b1;
      @(negedge clk); #1;
    end
    acc = cyc;
    for (int l = 0; l < LANES; l++)
      r[l] = op ? imm + DW'(l) : mdl[rs1][l] + mdl[rs2][l];
    for (int k = 0; k < G; k++) begin
      b.grp = k; b.rd = rd; b.cyc = acc + k + LAT;
      for (int u = 0; u < U; u++) begin
        b.mask[u] = mask[k*U+u];
        b.data[u*DW +: DW] = r[k*U+u];
      end
      exp_q.push_back(b);
    end
    for (int l = 0; l < LANES; l++) if (mask[l]) mdl[rd][l] = r[l];
    @(negedge clk);
    in_valid = 1'b0;
  endtask

  // monitor
  always @(negedge clk) begin
    if (rst_n && wb_valid) begin
      if (exp_q.size() == 0) begin
        chk(1'b0, "R1 extra beat", {{(U*DW-1){1'b0}}, wb_valid}, '0);
      end else begin
        beat_t e;
        logic [U*DW-1:0] m;
        e = exp_q.pop_front();
        for (int u = 0; u < U; u++) m[u*DW +: DW] = {DW{e.mask[u]}};
        chk(int'(wb_grp) == e.grp && int'(wb_rd) == e.rd, "R2 group/rd",
            {wb_rd, wb_grp}, {RW'(e.rd), GW'(e.grp)});
        chk(cyc == e.cyc, "R3 write-back cycle", cyc, e.cyc);
        chk(wb_mask == e.mask, "R7 lane mask", wb_mask, e.mask);
        chk((wb_data & m) == (e.data & m), "R8 lane data", wb_data & m, e.data & m);
      end
    end
  end

  task automatic wait_idle();
    while (busy) @(negedge clk);
    @(negedge clk);
  endtask

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      n_err++; n_chk++;
      $display("FAIL watchdog expired");
      $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_err);
      $finish;
    end
  end

  initial begin
    int ta, tb, tc, nb;
    bit st;
    for (int r = 0; r < NREG; r++) for (int l = 0; l < LANES; l++) mdl[r][l] = '0;
    repeat (3) @(negedge clk);
    // R9 reset state
    chk(in_ready == 1'b1, "R9 ready after reset", in_ready, 1);
    chk(busy == 1'b0, "R9 busy after reset", busy, 0);
    chk(wb_valid == 1'b0, "R9 no write-back in reset", wb_valid, 0);
    rst_n = 1'b1;
    @(negedge clk);

    // R9 registers read zero (r1 = r0 + r5)
    send(0, 1, 0, 5, '0, '1, ta, st);
    wait_idle();

    // R4 independent back-to-back loads, R8 lane-index load near wrap
    send(1, 1, 0, 0, 32'h0000_0100, '1, ta, st);
    send(1, 2, 0, 0, 32'hFFFF_FFF0, '1, tb, st);
    chk(tb - ta == G, "R4 independent issue spacing", tb - ta, G);
    // R5 read-after-write stall, R8 wraparound add
    send(0, 3, 1, 2, '0, '1, tc, st);
    chk(tc - tb == G + LAT, "R5 dependent issue spacing", tc - tb, G + LAT);
    chk(st == 1'b1, "R5 stall_o during dependency", st, 1);
    wait_idle();

    // R6 write-after-write stall
    send(1, 4, 0, 0, 32'h1234_0000, '1, ta, st);
    send(1, 4, 0, 0, 32'h5678_0000, 32'h0000_FFFF, tb, st);
    chk(tb - ta == G + LAT, "R6 same-destination spacing", tb - ta, G + LAT);
    wait_idle();

    // R1 two active lanes still take a full issue; R7 inactive lanes kept
    send(0, 5, 1, 1, '0, 32'h0000_0003, ta, st);
    send(1, 6, 0, 0, 32'hAAAA_0000, 32'h0000_0000, tb, st);
    chk(tb - ta == G, "R1 partial mask issue cycles", tb - ta, G);
    send(1, 0, 0, 0, 32'h7, '1, tc, st);
    chk(tc - tb == G, "R1 empty mask issue cycles", tc - tb, G);
    wait_idle();
    send(0, 7, 5, 6, '0, '1, ta, st);   // r5 + r6 reads masked results
    send(0, 7, 4, 3, '0, 32'h8000_0001, tb, st);
    send(0, 2, 7, 0, '0, '1, tc, st);   // read back r7 fully
    wait_idle();

    // R10 busy window
    send(1, 1, 0, 0, 32'h9, '1, ta, st);
    nb = 0;
    while (busy) begin nb++; @(negedge clk); end
    chk(nb == G - 1 + LAT, "R10 busy cycles", nb, G - 1 + LAT);
    repeat (LAT + 2) @(negedge clk);

    chk(exp_q.size() == 0, "R1 all beats delivered", exp_q.size(), 0);
    done = 1'b1;
    $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_err);
    $finish;
  end
endmodule